// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block carries out the entry half of exception processing for a processor core. The core pulses `start` with a vector number, both candidate program counters (the address after the current instruction and the address of the faulting instruction), the current status word, the supervisor stack pointer and a two-bit core-generation select. The block forces supervisor state and clears both trace bits. It then pushes a short frame onto the stack through a single-beat write port and fetches the handler address from the vector table with a long read. It reports the new status word, the new stack pointer, the new program counter and a cycle cost for the vector.

Three frame layouts exist. The first is a short frame of a PC long and a status word. The second is a frame that leads with a vector offset word. The third is a longer frame that carries both program counters. The layout is chosen from the generation select and the kind of exception. A second `start` that arrives while a frame is still being pushed or the handler is still being fetched counts as a nested fault. The block then stops in a halted state until reset.

Top module: `exc_frame_seq`

## Requirements
- R1: From the cycle after `start`, `sr_out` equals `sr_in` with bit 13 (supervisor) set, bits 15 and 14 (trace) cleared and every other bit, bit 12 included, unchanged. Frames stack the unmodified `sr_in`.
- R2: Each push first lowers the stack pointer by 4 for a long or by 2 for a word, then writes at the lowered address. After the last push, `sp_out` holds the address of that push.
- R3: Generation select 0 pushes the stacked PC as a long (`bus_long`=1), then the status word (`bus_long`=0, data in bits 15:0).
- R4: Where R3 and R5 do not apply, the frame is: the word `vec_num`×4, then the stacked PC long, then the status word.
- R5: The long frame is used for vectors 32–47 under select 2, and for vector 6 under selects 2 and 3. It pushes `pc_fault` as a long, then the word 0x2000 | ((`vec_num`×4) & 0x0FFF), then `pc_next` as a long, then the status word.
- R6: The stacked PC in the R3 and R4 frames is `pc_next` for vectors 5, 7, 9 and 24–47, and `pc_fault` for every other vector.
- R7: After the pushes, the block issues one long read at address `vec_num`×4. The read data appears on `pc_out`, and `done` is high for one cycle, exactly one cycle after that read is acknowledged.
- R8: A request (`bus_valid` with its address, data and size) holds steady until `bus_ready`. The block advances by one transfer per acknowledge.
- R9: A `start` while a push or the vector read is outstanding puts the block in the halted state within one cycle. `halted` then stays high, and no bus request and no `done` occur until reset, even if `start` is pulsed again.
- R10: `cycle_cost` is 40 for vectors 0, 1 and 6, 50 for vectors 2–3, 38 for vector 5, 44 for vectors 24–31 and 34 for all other vectors. It is valid from the cycle after `start`.
- R11: While reset is held and after it is released, `bus_valid`, `busy`, `done` and `halted` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin exception entry (single-cycle pulse) |
| vec_num | input | 8 | Exception vector number |
| variant | input | 2 | Core generation select (0–3) |
| pc_next | input | 32 | Address of the following instruction |
| pc_fault | input | 32 | Address of the faulting instruction |
| sr_in | input | 16 | Status word before entry |
| sp_in | input | 32 | Supervisor stack pointer before entry |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write (push), 0 = read (vector fetch) |
| bus_long | output | 1 | 1 = 32-bit transfer, 0 = 16-bit transfer |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data, words in bits 15:0 |
| bus_ready | input | 1 | Transfer acknowledge |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Push or vector read in progress |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Sticky nested-fault halt |
| sr_out | output | 16 | Status word after entry |
| sp_out | output | 32 | Stack pointer after the pushes |
| pc_out | output | 32 | Handler address read from the vector table |
| cycle_cost | output | 6 | Cycle cost of the vector |

## Verification
`sr_out` and `cycle_cost` are due one cycle after `start`, so they are sampled at the first falling edge after the pulse. Each push and the vector read complete at the rising edge that follows the bench's `bus_ready`. The bench records every transfer at the falling edge where it raises `bus_ready`, and it expects `done` at the falling edge one clock after the recorded read. A nested `start` must show `halted` at the next falling edge. The held-acknowledge test and the halt test then watch the bus over several falling edges to confirm that nothing moves.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {FRM_SHORT, FRM_OFS, FRM_LONG} frame_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PUSH, ST_FETCH, ST_FIN, ST_HALT} state_e;
  localparam int SR_SUP = 13;
  localparam int SR_TR0 = 14;
  localparam int SR_TR1 = 15;
  localparam logic [15:0] LONG_FRAME_TAG = 16'h2000;
endpackage

// File: rtl/exc_frame_plan.sv
module exc_frame_plan
  import exc_seq_pkg::*;
#(
  parameter int VW = 8,
  parameter int CW = 6
) (
  input  logic [VW-1:0] vec,
  input  logic [1:0]    variant,
  output frame_e        frame,
  output logic          use_next,
  output logic [1:0]    last_step,
  output logic [CW-1:0] cost
);
  logic is_trap, is_chk, is_auto;

  always_comb begin
    is_trap  = (vec >= VW'(32)) && (vec <= VW'(47));
    is_chk   = (vec == VW'(6));
    is_auto  = (vec >= VW'(24)) && (vec <= VW'(31));
    use_next = (vec == VW'(5)) || (vec == VW'(7)) || (vec == VW'(9)) || is_auto || is_trap;
    if (variant == 2'd0)                           frame = FRM_SHORT;
    else if (variant == 2'd2 && (is_trap || is_chk)) frame = FRM_LONG;
    else if (variant == 2'd3 && is_chk)            frame = FRM_LONG;
    else                                           frame = FRM_OFS;
    unique case (frame)
      FRM_SHORT: last_step = 2'd1;
      FRM_OFS:   last_step = 2'd2;
      default:   last_step = 2'd3;
    endcase
  end

  always_comb begin
    if (vec <= VW'(1))       cost = CW'(40);
    else if (vec <= VW'(3))  cost = CW'(50);
    else if (vec == VW'(5))  cost = CW'(38);
    else if (is_chk)         cost = CW'(40);
    else if (is_auto)        cost = CW'(44);
    else                     cost = CW'(34);
  end
endmodule

// File: rtl/exc_push_gen.sv
module exc_push_gen
  import exc_seq_pkg::*;
#(
  parameter int XW = 32,
  parameter int VW = 8
) (
  input  frame_e        frame,
  input  logic [1:0]    step,
  input  logic          use_next,
  input  logic [XW-1:0] pc_next,
  input  logic [XW-1:0] pc_fault,
  input  logic [15:0]   sr_old,
  input  logic [VW-1:0] vec,
  output logic          is_long,
  output logic [XW-1:0] data
);
  logic [15:0]   ofs_word;
  logic [XW-1:0] pc_stk;

  always_comb begin
    ofs_word = 16'({vec, 2'b00});
    pc_stk   = use_next ? pc_next : pc_fault;
    is_long  = 1'b0;
    data     = XW'(sr_old);
    unique case (frame)
      FRM_SHORT: if (step == 2'd0) begin is_long = 1'b1; data = pc_stk; end
      FRM_OFS: begin
        if (step == 2'd0)      data = XW'(ofs_word);
        else if (step == 2'd1) begin is_long = 1'b1; data = pc_stk; end
      end
      default: begin
        if (step == 2'd0)      begin is_long = 1'b1; data = pc_fault; end
        else if (step == 2'd1) data = XW'(LONG_FRAME_TAG | {4'h0, ofs_word[11:0]});
        else if (step == 2'd2) begin is_long = 1'b1; data = pc_next; end
      end
    endcase
  end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_seq_pkg::*;
#(
  parameter int XW = 32,
  parameter int VW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] vec_num,
  input  logic [1:0]    variant,
  input  logic [XW-1:0] pc_next,
  input  logic [XW-1:0] pc_fault,
  input  logic [15:0]   sr_in,
  input  logic [XW-1:0] sp_in,
  output logic          bus_valid,
  output logic          bus_write,
  output logic          bus_long,
  output logic [XW-1:0] bus_addr,
  output logic [XW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [XW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          halted,
  output logic [15:0]   sr_out,
  output logic [XW-1:0] sp_out,
  output logic [XW-1:0] pc_out,
  output logic [CW-1:0] cycle_cost
);
  state_e        state_q, state_d;
  logic [1:0]    step_q, step_d, last_step;
  logic [XW-1:0] sp_q, sp_d, pc_q, pc_d, pcn_q, pcn_d, pcf_q, pcf_d;
  logic [15:0]   sro_q, sro_d;
  logic [VW-1:0] vec_q, vec_d;
  logic [1:0]    var_q, var_d;
  frame_e        frame;
  logic          use_next, push_long, launch, nested, reg_en;
  logic [XW-1:0] push_data, push_addr;

  exc_frame_plan #(.VW(VW), .CW(CW)) u_plan (
    .vec(vec_q), .variant(var_q), .frame(frame), .use_next(use_next),
    .last_step(last_step), .cost(cycle_cost)
  );

  exc_push_gen #(.XW(XW), .VW(VW)) u_push (
    .frame(frame), .step(step_q), .use_next(use_next), .pc_next(pcn_q),
    .pc_fault(pcf_q), .sr_old(sro_q), .vec(vec_q), .is_long(push_long), .data(push_data)
  );

  assign push_addr = sp_q - (push_long ? XW'(4) : XW'(2));
  assign busy      = (state_q == ST_PUSH) || (state_q == ST_FETCH);
  assign done      = (state_q == ST_FIN);
  assign halted    = (state_q == ST_HALT);
  assign bus_valid = busy;
  assign bus_write = (state_q == ST_PUSH);
  assign bus_long  = (state_q == ST_PUSH) ? push_long : 1'b1;
  assign bus_addr  = (state_q == ST_FETCH) ? XW'({vec_q, 2'b00}) : push_addr;
  assign bus_wdata = (state_q == ST_PUSH) ? push_data : '0;
  assign sp_out    = sp_q;
  assign pc_out    = pc_q;

  always_comb begin
    sr_out         = sro_q;
    sr_out[SR_SUP] = 1'b1;
    sr_out[SR_TR1] = 1'b0;
    sr_out[SR_TR0] = 1'b0;
  end

  always_comb begin
    state_d = state_q; step_d = step_q; sp_d = sp_q; pc_d = pc_q;
    pcn_d = pcn_q; pcf_d = pcf_q; sro_d = sro_q; vec_d = vec_q; var_d = var_q;
    launch = start && (state_q == ST_IDLE || state_q == ST_FIN);
    nested = start && busy;
    if (nested) begin
      state_d = ST_HALT;
    end else if (launch) begin
      state_d = ST_PUSH; step_d = 2'd0; sp_d = sp_in; sro_d = sr_in;
      vec_d = vec_num; var_d = variant; pcn_d = pc_next; pcf_d = pc_fault;
    end else begin
      unique case (state_q)
        ST_PUSH: if (bus_ready) begin
          sp_d = push_addr;
          if (step_q == last_step) state_d = ST_FETCH;
          else                     step_d  = step_q + 2'd1;
        end
        ST_FETCH: if (bus_ready) begin
          pc_d = bus_rdata; state_d = ST_FIN;
        end
        ST_FIN:  state_d = ST_IDLE;
        default: ;
      endcase
    end
    reg_en = launch || (busy && bus_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0; sp_q <= '0; pc_q <= '0; pcn_q <= '0; pcf_q <= '0;
      sro_q   <= '0; vec_q <= '0; var_q <= '0;
    end else begin
      state_q <= state_d;
      if (reg_en) begin
        step_q <= step_d; sp_q <= sp_d; pc_q <= pc_d; pcn_q <= pcn_d;
        pcf_q  <= pcf_d;  sro_q <= sro_d; vec_q <= vec_d; var_q <= var_d;
      end
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !start |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_long));
  // R2
  sp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_ready && !start |=> sp_out == $past(bus_addr));
  // R7
  fetch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write |-> bus_long && bus_addr[1:0] == 2'b00);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !bus_valid && !done);
endmodule

// File: tb/sim_exc_frame_seq.sv
`timescale 1ns/1ps
module sim_exc_frame_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, bus_valid, bus_write, bus_long, busy, done, halted;
  logic bus_ready = 1'b0;
  logic [7:0] vec_num; logic [1:0] variant; logic [15:0] sr_in, sr_out;
  logic [31:0] pc_next, pc_fault, sp_in, bus_addr, bus_wdata, sp_out, pc_out;
  logic [31:0] bus_rdata = '0;
  logic [5:0] cycle_cost;

  exc_frame_seq u0 (.*);

  int checks = 0, fails = 0, cyc = 0, nw = 0, nr = 0, rcyc = 0;
  logic [31:0] wa [8]; logic [31:0] wd [8]; logic wl [8]; logic [31:0] ra;
  bit hold = 1'b0;

  // fields: vec(8) select(2) frame(2: 0 short,1 offset,2 long) next-pc(1) cost(6)
  localparam int NCASE = 18;
  localparam logic [18:0] TBL [NCASE] = '{
    {8'd4,  2'd0, 2'd0, 1'b0, 6'd34}, {8'd6,  2'd0, 2'd0, 1'b0, 6'd40},
    {8'd6,  2'd1, 2'd1, 1'b0, 6'd40}, {8'd6,  2'd2, 2'd2, 1'b0, 6'd40},
    {8'd6,  2'd3, 2'd2, 1'b0, 6'd40}, {8'd33, 2'd2, 2'd2, 1'b1, 6'd34},
    {8'd47, 2'd3, 2'd1, 1'b1, 6'd34}, {8'd32, 2'd0, 2'd0, 1'b1, 6'd34},
    {8'd5,  2'd1, 2'd1, 1'b1, 6'd38}, {8'd7,  2'd1, 2'd1, 1'b1, 6'd34},
    {8'd9,  2'd3, 2'd1, 1'b1, 6'd34}, {8'd24, 2'd1, 2'd1, 1'b1, 6'd44},
    {8'd31, 2'd2, 2'd1, 1'b1, 6'd44}, {8'd2,  2'd1, 2'd1, 1'b0, 6'd50},
    {8'd0,  2'd3, 2'd1, 1'b0, 6'd40}, {8'd8,  2'd2, 2'd1, 1'b0, 6'd34},
    {8'd48, 2'd2, 2'd1, 1'b0, 6'd34}, {8'd23, 2'd1, 2'd1, 1'b0, 6'd34}
  };

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bus_ready) bus_ready = 1'b0;
    else if (bus_valid && !hold) begin
      bus_ready = 1'b1;
      if (bus_write) begin
        if (nw < 8) begin wa[nw] = bus_addr; wd[nw] = bus_wdata; wl[nw] = bus_long; end
        nw++;
      end else begin
        ra = bus_addr; nr++; rcyc = cyc; bus_rdata = 32'hA000_0000 | bus_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; hold = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic launch(input logic [7:0] v, input logic [1:0] s);
    vec_num = v; variant = s; pc_next = 32'h0040_0106; pc_fault = 32'h0040_0100;
    sr_in = 16'hD71F; sp_in = 32'h0000_8000; nw = 0; nr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output int dcyc);
    int t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    chk(done, "R7", "done seen", 32'(done), 32'd1);
    dcyc = cyc;
  endtask

  task automatic run_case(input int i);
    logic [7:0] v; logic [1:0] s, f; logic nx; logic [5:0] c;
    logic [31:0] ea [4]; logic [31:0] ed [4]; logic el [4];
    logic [31:0] pcx, ow; int n, dcyc; bit ok; string tag;
    {v, s, f, nx, c} = TBL[i];
    launch(v, s);
    chk(sr_out == 16'h371F, "R1", "status after entry", 32'(sr_out), 32'h371F);
    chk(cycle_cost == c, "R10", "cycle cost", 32'(cycle_cost), 32'(c));
    wait_done(dcyc);
    pcx = nx ? 32'h0040_0106 : 32'h0040_0100;
    ow  = {22'd0, v, 2'b00};
    if (f == 2'd0) begin
      n = 2; tag = "R3";
      ea[0] = 32'h7FFC; el[0] = 1; ed[0] = pcx;
      ea[1] = 32'h7FFA; el[1] = 0; ed[1] = 32'hD71F;
    end else if (f == 2'd1) begin
      n = 3; tag = "R4";
      ea[0] = 32'h7FFE; el[0] = 0; ed[0] = ow;
      ea[1] = 32'h7FFA; el[1] = 1; ed[1] = pcx;
      ea[2] = 32'h7FF8; el[2] = 0; ed[2] = 32'hD71F;
    end else begin
      n = 4; tag = "R5";
      ea[0] = 32'h7FFC; el[0] = 1; ed[0] = 32'h0040_0100;
      ea[1] = 32'h7FFA; el[1] = 0; ed[1] = 32'h2000 | (ow & 32'h0FFF);
      ea[2] = 32'h7FF6; el[2] = 1; ed[2] = 32'h0040_0106;
      ea[3] = 32'h7FF4; el[3] = 0; ed[3] = 32'hD71F;
    end
    chk(nw == n, tag, "push count", 32'(nw), 32'(n));
    for (int k = 0; k < n && k < nw; k++) begin
      ok = (wa[k] == ea[k]) && (wd[k] == ed[k]) && (wl[k] == el[k]);
      chk(ok, tag, $sformatf("push %0d addr/data", k), wd[k] ^ wa[k], ed[k] ^ ea[k]);
    end
    if (f != 2'd2) begin
      int pi = (f == 2'd0) ? 0 : 1;
      chk(wd[pi] == pcx, "R6", "stacked pc", wd[pi], pcx);
    end
    chk(sp_out == ea[n-1], "R2", "final stack pointer", sp_out, ea[n-1]);
    chk(nr == 1 && ra == ow, "R7", "vector read address", ra, ow);
    chk(pc_out == (32'hA000_0000 | ow), "R7", "handler pc", pc_out, 32'hA000_0000 | ow);
    chk(dcyc == rcyc + 1, "R7", "done timing", 32'(dcyc), 32'(rcyc + 1));
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", "run expired", 32'(cyc), 32'd0);
    finish_up();
  end

  initial begin
    int dc, nw_at;
    logic [31:0] a0;
    bit steady;
    rst_n = 1'b0; start = 1'b0;
    @(negedge clk);
    chk(!bus_valid && !busy && !done && !halted, "R11", "outputs in reset",
        {bus_valid, busy, done, halted}, 32'd0);
    do_reset();
    chk(!bus_valid && !busy && !done && !halted, "R11", "outputs after reset",
        {bus_valid, busy, done, halted}, 32'd0);

    for (int i = 0; i < NCASE; i++) run_case(i);

    // R8: acknowledge withheld, request must not move
    hold = 1'b1;
    launch(8'd4, 2'd1);
    a0 = bus_addr; steady = bus_valid;
    repeat (5) begin
      @(negedge clk);
      steady = steady && bus_valid && (bus_addr == a0) && (bus_wdata == 32'h0010);
    end
    chk(steady && a0 == 32'h7FFE, "R8", "held request", bus_addr, 32'h7FFE);
    hold = 1'b0;
    wait_done(dc);
    chk(sp_out == 32'h7FF8, "R8", "frame after stall", sp_out, 32'h7FF8);
    @(negedge clk);

    // R9: nested start while pushing
    launch(8'd6, 2'd2);
    while (nw < 1) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(halted, "R9", "halt on nested start", 32'(halted), 32'd1);
    nw_at = nw; steady = 1'b1;
    repeat (4) begin @(negedge clk); steady = steady && !bus_valid && !done && halted; end
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (4) begin @(negedge clk); steady = steady && !bus_valid && !done && halted; end
    chk(steady && nw == nw_at, "R9", "quiet while halted", 32'(nw), 32'(nw_at));
    do_reset();
    chk(!halted && !bus_valid, "R11", "reset leaves halt", 32'(halted), 32'd0);
    run_case(3);
    finish_up();
  end
endmodule